// File: doc/BRIEF.md
# Three-Group Interrupt Priority Encoder

This block gathers interrupt requests from three source groups (critical, main and peripheral). It removes the sources that software has disabled and registers one 32-bit encoded status word. For each group the word holds a valid flag and the number of the winning source. Software reads the critical field first, then the main field, then the peripheral field, and services the first valid one. The fixed bit positions of the fields let it do this without scanning request vectors. Critical is therefore the most urgent group, main comes next and peripheral comes last.

A peripheral source can be promoted by one of two per-source boost-enable inputs. A high boost makes the request show up in the critical field. A low boost makes it show up in the main field. In both cases it appears there as a reserved code, and the real source number is read from the peripheral field. The main and peripheral groups each have a mask register, reached through a small register port. The same port also reads back the status word. Critical sources have no mask. Per-source priority levels are held at zero, and pin edge detection is not part of this block.

Top module: `irq_group_encoder`

## Requirements
- R1: While reset is asserted and just after it is released, the main mask reads 0x00010fff, the peripheral mask reads 0x7ffffc00 and the status word is 0.
- R2: Main source n is disabled by main-mask bit 16-n, and peripheral source n is disabled by peripheral-mask bit 31-n (1 means disabled). Mask bits that map to no source read as 0 and ignore writes, so a write of all ones reads back as 0x0001ffff (main) and 0xfffffc00 (peripheral).
- R3: Status layout: critical valid at bit 10 with its code in bits 9:8, main valid at bit 21 with its code in bits 20:16, peripheral valid at bit 29 with its code in bits 28:24. All other bits are 0. A field with no candidate has valid 0 and code 0.
- R4: Within a field, the lowest-numbered pending candidate wins. Critical candidates are codes 0, 1 and 3 (request bits 0, 1, 3) plus the high-boost code. Main candidates are unmasked sources 0 to 16 plus the low-boost code.
- R5: Critical request bit 2 and main request bit 4 are ignored, because those codes are reserved.
- R6: If any pending, unmasked peripheral source has its high-boost enable set, code 2 becomes a critical candidate.
- R7: If any pending, unmasked peripheral source has its low-boost enable set and its high-boost enable clear, code 4 becomes a main candidate. High boost takes precedence when both enables are set.
- R8: The peripheral field is valid whenever any unmasked peripheral source is pending. Its code is chosen in this order: the lowest-numbered high-boosted source, otherwise the lowest-numbered low-boosted source, otherwise the lowest-numbered pending source.
- R9: The status word is registered. It reflects requests, boosts and masks as they stood at the previous rising clock edge. A mask write therefore becomes visible one edge after the write is captured.
- R10: Address 0 selects the main mask, address 1 the peripheral mask, address 2 the status word and address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 4 | Critical requests by code (bit 2 ignored) |
| main_req | input | NUM_MAIN | Main-group requests (bit 4 ignored) |
| per_req | input | NUM_PER | Peripheral-group requests |
| boost_hi | input | NUM_PER | Per-source high-boost enable |
| boost_lo | input | NUM_PER | Per-source low-boost enable |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| status_word | output | 32 | Registered encoded status |

## Verification
The bench aims at the boosted paths. A source with both boost enables set must land in the critical field only. A design that did not exclude it from the low-boost set would also raise main code 4. A design that picked the peripheral code by plain order would name the wrong source behind a reserved code. The bench also probes the reversed mask bit mapping and the reserved request bits, since an off-by-one mapping masks the neighbouring source, and a live reserved bit shows a phantom code 2 or 4. It checks the one-edge latency of both request and mask changes, because a combinational or doubly registered status shows up early or late. It also checks that writes to the status address leave both masks alone.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

    localparam int unsigned WORD_W = 32;

    // mask registers: reset values and the bit that governs source 0
    localparam logic [WORD_W-1:0] MAIN_MASK_RST = 32'h0001_0fff;
    localparam logic [WORD_W-1:0] PER_MASK_RST  = 32'h7fff_fc00;
    localparam int unsigned MAIN_TOP_BIT = 16;
    localparam int unsigned PER_TOP_BIT  = 31;

    // status word field placement
    localparam int unsigned CRIT_CODES   = 4;
    localparam int unsigned CRIT_VLD_BIT = 10;
    localparam int unsigned CRIT_LSB     = 8;
    localparam int unsigned CRIT_CW      = 2;
    localparam int unsigned MAIN_VLD_BIT = 21;
    localparam int unsigned MAIN_LSB     = 16;
    localparam int unsigned MAIN_CW      = 5;
    localparam int unsigned PER_VLD_BIT  = 29;
    localparam int unsigned PER_LSB      = 24;
    localparam int unsigned PER_CW       = 5;

    // reserved codes carrying promoted peripheral requests
    localparam int unsigned CRIT_BOOST_CODE = 2;
    localparam int unsigned MAIN_BOOST_CODE = 4;

    typedef enum logic [1:0] {
        SEL_MAIN_MASK = 2'd0,
        SEL_PER_MASK  = 2'd1,
        SEL_STATUS    = 2'd2,
        SEL_SPARE     = 2'd3
    } reg_sel_e;

    // bits top, top-1, ... top-(cnt-1) set: the mask bits that own a source
    function automatic logic [WORD_W-1:0] mask_span(input int unsigned top,
                                                    input int unsigned cnt);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int unsigned n = 0; n < cnt; n++) begin
            v[top-n] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] field_span();
        logic [WORD_W-1:0] v;
        v = '0;
        v[CRIT_VLD_BIT] = 1'b1;
        v[MAIN_VLD_BIT] = 1'b1;
        v[PER_VLD_BIT]  = 1'b1;
        v[CRIT_LSB +: CRIT_CW] = '1;
        v[MAIN_LSB +: MAIN_CW] = '1;
        v[PER_LSB  +: PER_CW]  = '1;
        return v;
    endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned W  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irqenc_pkg::*;
#(
    parameter int unsigned NUM_MAIN = 17,
    parameter int unsigned NUM_PER  = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          reg_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [WORD_W-1:0]   status_q,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_MAIN-1:0] main_en,
    output logic [NUM_PER-1:0]  per_en
);

    localparam logic [WORD_W-1:0] MAIN_WMASK = mask_span(MAIN_TOP_BIT, NUM_MAIN);
    localparam logic [WORD_W-1:0] PER_WMASK  = mask_span(PER_TOP_BIT, NUM_PER);
    localparam logic [WORD_W-1:0] MAIN_RST   = MAIN_MASK_RST & MAIN_WMASK;
    localparam logic [WORD_W-1:0] PER_RST    = PER_MASK_RST & PER_WMASK;

    reg_sel_e          sel;
    logic [WORD_W-1:0] main_q;
    logic [WORD_W-1:0] per_q;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= MAIN_RST;
            per_q  <= PER_RST;
        end else if (wr_en) begin
            unique case (sel)
                SEL_MAIN_MASK: main_q <= wr_data & MAIN_WMASK;
                SEL_PER_MASK:  per_q  <= wr_data & PER_WMASK;
                SEL_STATUS:    ;
                SEL_SPARE:     ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MAIN_MASK: rd_data = main_q;
            SEL_PER_MASK:  rd_data = per_q;
            SEL_STATUS:    rd_data = status_q;
            SEL_SPARE:     rd_data = '0;
        endcase
    end

    // reversed bit mapping: source n sits at top-n, a 1 disables it
    for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main_en
        assign main_en[n] = ~main_q[MAIN_TOP_BIT-n];
    end
    for (genvar n = 0; n < NUM_PER; n++) begin : g_per_en
        assign per_en[n] = ~per_q[PER_TOP_BIT-n];
    end

    // R10: the status and spare addresses are not writable
    p_ro_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == 2'd2 || reg_addr == 2'd3))
        |=> ($stable(main_en) && $stable(per_en)))
        else $error("p_ro_status_r10");

    // R2: a main-mask write governs source 0 through data bit 16
    p_main_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd0) |=> (main_en[0] == !$past(wr_data[MAIN_TOP_BIT])))
        else $error("p_main_map_r2");

    // R2: a peripheral-mask write governs source 0 through data bit 31
    p_per_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd1) |=> (per_en[0] == !$past(wr_data[PER_TOP_BIT])))
        else $error("p_per_map_r2");

endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
    import irqenc_pkg::*;
#(
    parameter int unsigned NUM_MAIN = 17,
    parameter int unsigned NUM_PER  = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CRIT_CODES-1:0] crit_req,
    input  logic [NUM_MAIN-1:0]   main_req,
    input  logic [NUM_PER-1:0]    per_req,
    input  logic [NUM_PER-1:0]    boost_hi,
    input  logic [NUM_PER-1:0]    boost_lo,
    input  logic [NUM_MAIN-1:0]   main_en,
    input  logic [NUM_PER-1:0]    per_en,
    output logic [WORD_W-1:0]     status_q
);

    localparam int unsigned CIDX_W = $clog2(CRIT_CODES);
    localparam int unsigned MIDX_W = $clog2(NUM_MAIN);
    localparam int unsigned PIDX_W = $clog2(NUM_PER);
    localparam logic [WORD_W-1:0] FIELD_MASK = field_span();

    logic [NUM_PER-1:0]    per_live, hi_set, lo_set;
    logic [CRIT_CODES-1:0] crit_cand;
    logic [NUM_MAIN-1:0]   main_cand;
    logic                  crit_any, main_any, hi_any, lo_any, per_any;
    logic [CIDX_W-1:0]     crit_idx;
    logic [MIDX_W-1:0]     main_idx;
    logic [PIDX_W-1:0]     hi_idx, lo_idx, all_idx, per_idx;
    logic [WORD_W-1:0]     status_d;

    assign per_live = per_req & per_en;
    assign hi_set   = per_live & boost_hi;
    assign lo_set   = per_live & boost_lo & ~boost_hi;

    always_comb begin
        crit_cand = crit_req;
        crit_cand[CRIT_BOOST_CODE] = hi_any;
        main_cand = main_req & main_en;
        main_cand[MAIN_BOOST_CODE] = lo_any;
    end

    irq_lowest_pick #(.W(CRIT_CODES), .IW(CIDX_W)) u_pick_crit (
        .vec(crit_cand), .any(crit_any), .idx(crit_idx));
    irq_lowest_pick #(.W(NUM_MAIN), .IW(MIDX_W)) u_pick_main (
        .vec(main_cand), .any(main_any), .idx(main_idx));
    irq_lowest_pick #(.W(NUM_PER), .IW(PIDX_W)) u_pick_hi (
        .vec(hi_set), .any(hi_any), .idx(hi_idx));
    irq_lowest_pick #(.W(NUM_PER), .IW(PIDX_W)) u_pick_lo (
        .vec(lo_set), .any(lo_any), .idx(lo_idx));
    irq_lowest_pick #(.W(NUM_PER), .IW(PIDX_W)) u_pick_all (
        .vec(per_live), .any(per_any), .idx(all_idx));

    always_comb begin
        if (hi_any)      per_idx = hi_idx;
        else if (lo_any) per_idx = lo_idx;
        else             per_idx = all_idx;
    end

    always_comb begin
        status_d = '0;
        status_d[CRIT_VLD_BIT] = crit_any;
        status_d[MAIN_VLD_BIT] = main_any;
        status_d[PER_VLD_BIT]  = per_any;
        if (crit_any) status_d[CRIT_LSB +: CRIT_CW] = CRIT_CW'(crit_idx);
        if (main_any) status_d[MAIN_LSB +: MAIN_CW] = MAIN_CW'(main_idx);
        if (per_any)  status_d[PER_LSB  +: PER_CW]  = PER_CW'(per_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R3: bits outside the three fields stay clear
    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~FIELD_MASK) == '0)
        else $error("p_rsv_zero_r3");

    // R3: an idle field carries code 0
    p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[CRIT_VLD_BIT] || status_q[CRIT_LSB +: CRIT_CW] == '0) &&
        (status_q[MAIN_VLD_BIT] || status_q[MAIN_LSB +: MAIN_CW] == '0) &&
        (status_q[PER_VLD_BIT]  || status_q[PER_LSB  +: PER_CW]  == '0))
        else $error("p_idle_code_r3");

    // R6: the high-boost code implies a live peripheral field
    p_hi_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[CRIT_VLD_BIT] && status_q[CRIT_LSB +: CRIT_CW] == CRIT_CW'(CRIT_BOOST_CODE))
        |-> status_q[PER_VLD_BIT])
        else $error("p_hi_link_r6");

    // R7: the low-boost code implies a live peripheral field
    p_lo_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[MAIN_VLD_BIT] && status_q[MAIN_LSB +: MAIN_CW] == MAIN_CW'(MAIN_BOOST_CODE))
        |-> status_q[PER_VLD_BIT])
        else $error("p_lo_link_r7");

    // R4: a main code never exceeds the source count
    p_main_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[MAIN_VLD_BIT] |-> (32'(status_q[MAIN_LSB +: MAIN_CW]) < NUM_MAIN))
        else $error("p_main_range_r4");

    // R9: peripheral valid follows requests of the previous edge
    p_per_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[PER_VLD_BIT] |-> $past(|(per_req & per_en)))
        else $error("p_per_track_r9");

endmodule

// File: rtl/irq_group_encoder.sv
module irq_group_encoder
    import irqenc_pkg::*;
#(
    parameter int unsigned NUM_MAIN = 17,
    parameter int unsigned NUM_PER  = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          crit_req,
    input  logic [NUM_MAIN-1:0] main_req,
    input  logic [NUM_PER-1:0]  per_req,
    input  logic [NUM_PER-1:0]  boost_hi,
    input  logic [NUM_PER-1:0]  boost_lo,
    input  logic                wr_en,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic [31:0]         status_word
);

    logic [NUM_MAIN-1:0] main_en;
    logic [NUM_PER-1:0]  per_en;
    logic [WORD_W-1:0]   status_q;

    irq_mask_bank #(.NUM_MAIN(NUM_MAIN), .NUM_PER(NUM_PER)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .status_q (status_q),
        .rd_data  (rd_data),
        .main_en  (main_en),
        .per_en   (per_en)
    );

    irq_status_enc #(.NUM_MAIN(NUM_MAIN), .NUM_PER(NUM_PER)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .crit_req (crit_req),
        .main_req (main_req),
        .per_req  (per_req),
        .boost_hi (boost_hi),
        .boost_lo (boost_lo),
        .main_en  (main_en),
        .per_en   (per_en),
        .status_q (status_q)
    );

    assign status_word = status_q;

endmodule

// File: tb/test_irq_group_encoder.sv
`timescale 1ns/1ps
module test_irq_group_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  crit = '0;
    logic [16:0] mreq = '0;
    logic [21:0] preq = '0;
    logic [21:0] bh = '0;
    logic [21:0] bl = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd2;
    logic [31:0] wdat = '0;
    logic [31:0] rd_data, status_word;

    logic [31:0] mm = 32'h0001_0fff;
    logic [31:0] pm = 32'h7fff_fc00;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_group_encoder i_irq_group_encoder (
        .clk(clk), .rst_n(rst_n), .crit_req(crit), .main_req(mreq),
        .per_req(preq), .boost_hi(bh), .boost_lo(bl), .wr_en(wr_en),
        .reg_addr(addr), .wr_data(wdat), .rd_data(rd_data),
        .status_word(status_word)
    );

    function automatic logic [31:0] model(input logic [3:0] c, input logic [16:0] m,
                                          input logic [21:0] p, input logic [21:0] h,
                                          input logic [21:0] l, input logic [31:0] mmask,
                                          input logic [31:0] pmask);
        logic [31:0] s;
        int hi = -1, lo = -1, all = -1, cc = -1, mc = -1, pc;
        s = '0;
        for (int n = 0; n < 22; n++) begin
            if (p[n] && !pmask[31-n]) begin
                if (all < 0) all = n;
                if (h[n]) begin
                    if (hi < 0) hi = n;
                end else if (l[n]) begin
                    if (lo < 0) lo = n;
                end
            end
        end
        for (int k = 3; k >= 0; k--) begin
            if ((k == 2) ? (hi >= 0) : c[k]) cc = k;
        end
        for (int k = 16; k >= 0; k--) begin
            if ((k == 4) ? (lo >= 0) : (m[k] && !mmask[16-k])) mc = k;
        end
        pc = (hi >= 0) ? hi : ((lo >= 0) ? lo : all);
        if (cc >= 0) begin s[10] = 1'b1; s[9:8]   = 2'(cc); end
        if (mc >= 0) begin s[21] = 1'b1; s[20:16] = 5'(mc); end
        if (pc >= 0) begin s[29] = 1'b1; s[28:24] = 5'(pc); end
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdat = d; wr_en = 1'b1;
        @(posedge clk);
        if (a == 2'd0) mm = d & 32'h0001_ffff;
        if (a == 2'd1) pm = d & 32'hffff_fc00;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a; #1; v = rd_data; addr = 2'd2;
    endtask

    function automatic logic [31:0] expect_now();
        return model(crit, mreq, preq, bh, bl, mm, pm);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] prev;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(2'd0, v); chk("R1 main mask reset", v, 32'h0001_0fff);
        rd(2'd1, v); chk("R1 per mask reset", v, 32'h7fff_fc00);
        chk("R1 status in reset", status_word, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 status after reset", status_word, 32'h0);

        // R2: unused mask bits
        wr(2'd0, 32'hffff_ffff); rd(2'd0, v); chk("R2 main unused bits", v, 32'h0001_ffff);
        wr(2'd1, 32'hffff_ffff); rd(2'd1, v); chk("R2 per unused bits", v, 32'hffff_fc00);
        // R2: mapping - disable main 5 (bit 11) and per 3 (bit 28)
        wr(2'd0, 32'h0000_0800);
        wr(2'd1, 32'h1000_0000);
        mreq = 17'h000a0; preq = 22'h48; // main 5,7 ; per 3,6
        step();
        chk("R2 main bit 16-n", status_word, {2'b00, 1'b1, 5'd6, 2'b00, 1'b1, 5'd7, 5'b0, 1'b0, 2'd0, 8'h0});
        chk("R2 model", status_word, expect_now());

        // R9: registered timing on a request change
        prev = status_word;
        crit = 4'b1000; #1;
        chk("R9 no change before edge", status_word, prev);
        step();
        chk("R9 change after edge", status_word, expect_now());
        // R9: mask write latency
        wr(2'd0, 32'h0000_0000); // enables main 5 on this edge
        chk("R9 mask not yet visible", status_word[20:16], 5'd7);
        step();
        chk("R9 mask visible", status_word[20:16], 5'd5);

        // R4: lowest critical, lowest main
        crit = 4'b1010; mreq = 17'h10008; preq = '0;
        step();
        chk("R4 crit lowest", status_word, 32'h0023_0500);
        // R5: reserved bits ignored
        crit = 4'b0100; mreq = 17'h00010;
        step();
        chk("R5 reserved request bits", status_word, 32'h0);

        // R6: high boost beats crit 3 but not crit 1
        wr(2'd1, 32'h0000_0000);
        crit = 4'b1000; preq = 22'h200; bh = 22'h200; bl = '0;
        step();
        chk("R6 hi boost code 2", status_word, 32'h2900_0600);
        crit = 4'b1010;
        step();
        chk("R6 crit 1 beats boost", status_word, 32'h2900_0500);

        // R7: low boost, main source 9 pending
        crit = '0; mreq = 17'h00200; preq = 22'h20; bh = '0; bl = 22'h20;
        step();
        chk("R7 lo boost code 4", status_word, 32'h2524_0000);
        // R7: both enables set counts as high only
        bh = 22'h20;
        step();
        chk("R7 hi precedence", status_word, 32'h2529_0600);

        // R8: per field order hi > lo > plain
        mreq = '0; preq = 22'h1084; bh = 22'h1000; bl = 22'h80;
        step();
        chk("R8 hi source chosen", status_word, 32'h2c24_0600);
        bh = '0;
        step();
        chk("R8 lo source chosen", status_word, 32'h2724_0000);
        bl = '0;
        step();
        chk("R8 plain lowest", status_word, 32'h2200_0000);
        // R3: peripheral masked -> per field idle
        wr(2'd1, 32'hffff_ffff);
        step();
        chk("R3 idle field", status_word, 32'h0);

        // R10: read-only status and spare address
        wr(2'd2, 32'h0000_0000); wr(2'd3, 32'h0000_0000);
        rd(2'd0, v); chk("R10 main mask kept", v, 32'h0000_0000);
        rd(2'd1, v); chk("R10 per mask kept", v, 32'hffff_fc00);
        rd(2'd3, v); chk("R10 spare reads 0", v, 32'h0);

        // random phase
        for (int it = 0; it < 600; it++) begin
            if (it % 25 == 0) begin
                wr(2'd0, $urandom);
                wr(2'd1, $urandom);
            end
            crit = 4'($urandom);
            mreq = 17'($urandom & $urandom);
            preq = 22'($urandom & $urandom & $urandom);
            bh   = 22'($urandom & $urandom & $urandom);
            bl   = 22'($urandom & $urandom);
            step();
            chk("R4 R8 random status", status_word, expect_now());
            rd(2'd2, v);
            chk("R10 random status read", v, expect_now());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule